// File: doc/BRIEF.md
# GPIO Interrupt Detector

This block watches a group of general-purpose input pins and turns configured pin activity into interrupt events. Each pin has three control bits. A trigger-kind bit chooses edge or level detection. A polarity bit chooses which edge or which level counts. A sense-off bit stops the pin from being watched. Every detected event is caught in a sticky status bit. Software clears status bits by writing ones to them. A per-pin enable word decides which status bits reach the single interrupt line.

The pin levels are expected to be synchronised already. The block has no streaming data path, so every pin is a plain control or status signal. The status-clear, enable-set and enable-clear inputs are one-cycle strobes. There is no back-pressure: each strobe is applied in the cycle it is seen. A typical handler reads `status_o`, clears the bits it will service, and then services them. An edge that arrives after the clear sets its bit again, so it is not lost.

Top module: `gpio_irq_detect`

## Requirements
- R1: During reset and after reset is released, `status_o`, `enable_o` and `irq_o` are all zero. The stored previous sample of every pin is 0.
- R2: With trigger-kind 0 and polarity 0, a pin whose level is 1 while its previous sample was 0 sets its status bit at the next clock edge. The bit is visible in the cycle after that edge.
- R3: With trigger-kind 0 and polarity 1, a pin whose level is 0 while its previous sample was 1 sets its status bit at the next clock edge.
- R4: With trigger-kind 1 and polarity 0, a pin held at level 0 sets its status bit. The bit sets again on the edge right after a clear for as long as the level stays 0.
- R5: With trigger-kind 1 and polarity 1, a pin held at level 1 sets its status bit. The bit sets again after a clear while the level stays 1.
- R6: When `clr_valid_i` is high, each status bit whose `clr_mask_i` bit is 1 becomes 0, and each bit whose mask bit is 0 keeps its value. An all-ones mask clears the whole word. Status bits never set without a detected event.
- R7: A detected event and a clear of the same status bit in the same cycle leave that bit set.
- R8: A pin with its sense-off bit at 1 never sets its status bit, and its previous sample is held at 0. When sensing is turned back on in rising mode, a pin already at level 1 counts as a rising edge.
- R9: Status bits latch whether or not the pin is enabled.
- R10: `en_set_i` sets and `en_clr_i` clears the enable bits at the positions where they are 1. Other enable bits keep their values. Set wins when both target the same bit.
- R11: `irq_o` is 1 exactly when some bit is 1 in both `status_o` and `enable_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_level_i | input | NUM_PINS | Synchronised pin levels |
| trig_level_i | input | NUM_PINS | Trigger kind per pin: 0 edge, 1 level |
| trig_invert_i | input | NUM_PINS | Polarity per pin (see R2–R5) |
| sense_off_i | input | NUM_PINS | 1 disables sensing of the pin |
| clr_valid_i | input | 1 | Strobe: apply write-one-to-clear |
| clr_mask_i | input | NUM_PINS | Bits to clear when strobed |
| en_set_i | input | NUM_PINS | Enable bits to set this cycle |
| en_clr_i | input | NUM_PINS | Enable bits to clear this cycle |
| status_o | output | NUM_PINS | Sticky event status word |
| enable_o | output | NUM_PINS | Interrupt enable word |
| irq_o | output | 1 | OR of enabled status bits |

## Verification
Assertions check several properties on every cycle:
- A cleared bit without a coincident event reads 0.
- A coincident event wins over a clear.
- No status bit appears without an event.
- An edge event in edge mode implies the pin changed.
- A sensed-off pin cannot become pending.
- Enable bits hold when no strobe targets them.
- The interrupt line stays low with an empty enable word.

Only the bench scenarios can show that each of the four trigger encodings picks the right edge or level. They also show that level triggers re-arm right after a clear, and that a pin re-enabled while high produces its rising edge. Finally, they show that masked pins still latch and raise the line once enabled.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  // {trigger-kind, polarity} decode
  typedef enum logic [1:0] {
    TRIG_RISE = 2'b00,
    TRIG_FALL = 2'b01,
    TRIG_LOW  = 2'b10,
    TRIG_HIGH = 2'b11
  } trig_mode_e;
endpackage

// File: rtl/gpio_irq_pin_det.sv
module gpio_irq_pin_det
  import gpio_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic trig_level_i,
  input  logic trig_invert_i,
  input  logic sense_off_i,
  output logic event_o
);
  logic       prev_q;
  logic       raw_evt;
  trig_mode_e mode;

  assign mode = trig_mode_e'({trig_level_i, trig_invert_i});

  // previous sample held at reset value while sensing is off
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           prev_q <= 1'b0;
    else if (sense_off_i) prev_q <= 1'b0;
    else                  prev_q <= level_i;
  end

  always_comb begin
    case (mode)
      TRIG_RISE: raw_evt = level_i & ~prev_q;
      TRIG_FALL: raw_evt = ~level_i & prev_q;
      TRIG_LOW:  raw_evt = ~level_i;
      TRIG_HIGH: raw_evt = level_i;
      default:   raw_evt = 1'b0;
    endcase
  end

  assign event_o = raw_evt & ~sense_off_i;

  // R2/R3: edge mode only fires on a change of the pin
  a_r2_edge_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_level_i && event_o) |-> (level_i != prev_q));
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] evt_i,
  input  logic                clr_valid_i,
  input  logic [NUM_PINS-1:0] clr_mask_i,
  output logic [NUM_PINS-1:0] status_o
);
  localparam logic [NUM_PINS-1:0] NONE = '0;

  logic [NUM_PINS-1:0] status_q;
  logic [NUM_PINS-1:0] clr_eff;

  assign clr_eff = clr_valid_i ? clr_mask_i : NONE;

  // set has priority over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= NONE;
    else        status_q <= (status_q & ~clr_eff) | evt_i;
  end

  assign status_o = status_q;

  a_r6_cleared_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid_i |=> ((status_q & $past(clr_mask_i & ~evt_i)) == NONE));

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != NONE) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

  a_r6_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(evt_i)) == NONE));
endmodule

// File: rtl/gpio_irq_enable.sv
module gpio_irq_enable #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] set_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] enable_o
);
  localparam logic [NUM_PINS-1:0] NONE = '0;

  logic [NUM_PINS-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= NONE;
    else        en_q <= (en_q & ~clr_i) | set_i;
  end

  assign enable_o = en_q;

  a_r10_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != NONE) |=> ((en_q & $past(set_i)) == $past(set_i)));

  a_r10_untouched_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i | clr_i) == NONE) |=> $stable(en_q));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_level_i,
  input  logic [NUM_PINS-1:0] trig_level_i,
  input  logic [NUM_PINS-1:0] trig_invert_i,
  input  logic [NUM_PINS-1:0] sense_off_i,
  input  logic                clr_valid_i,
  input  logic [NUM_PINS-1:0] clr_mask_i,
  input  logic [NUM_PINS-1:0] en_set_i,
  input  logic [NUM_PINS-1:0] en_clr_i,
  output logic [NUM_PINS-1:0] status_o,
  output logic [NUM_PINS-1:0] enable_o,
  output logic                irq_o
);
  localparam logic [NUM_PINS-1:0] NONE = '0;

  logic [NUM_PINS-1:0] pin_evt;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    gpio_irq_pin_det u_det (
      .clk           (clk),
      .rst_n         (rst_n),
      .level_i       (pin_level_i[g]),
      .trig_level_i  (trig_level_i[g]),
      .trig_invert_i (trig_invert_i[g]),
      .sense_off_i   (sense_off_i[g]),
      .event_o       (pin_evt[g])
    );

    a_r8_off_stays_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (!status_o[g] && sense_off_i[g]) |=> !status_o[g]);
  end

  gpio_irq_status #(.NUM_PINS(NUM_PINS)) u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (pin_evt),
    .clr_valid_i (clr_valid_i),
    .clr_mask_i  (clr_mask_i),
    .status_o    (status_o)
  );

  gpio_irq_enable #(.NUM_PINS(NUM_PINS)) u_enable (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (en_set_i),
    .clr_i    (en_clr_i),
    .enable_o (enable_o)
  );

  assign irq_o = |(status_o & enable_o);

  a_r11_quiet_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_o == NONE) |-> !irq_o);
endmodule

// File: tb/gpio_irq_detect_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_detect_tb_top;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin = '0, trig = '0, inv = '0, dis = '0;
  logic         clr_v = 1'b0;
  logic [N-1:0] clr_m = '0, en_s = '0, en_c = '0;
  logic [N-1:0] status, enable;
  logic         irq;

  int checks = 0;
  int fails  = 0;
  string tag = "R1";

  // reference model state
  bit [N-1:0] m_st, m_en, m_prv;

  always #4 clk = ~clk;

  gpio_irq_detect #(.NUM_PINS(N)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .pin_level_i(pin), .trig_level_i(trig), .trig_invert_i(inv),
    .sense_off_i(dis), .clr_valid_i(clr_v), .clr_mask_i(clr_m),
    .en_set_i(en_s), .en_clr_i(en_c),
    .status_o(status), .enable_o(enable), .irq_o(irq)
  );

  task automatic model_update();
    bit ev;
    bit [N-1:0] nst, nen, nprv;
    if (!rst_n) begin
      m_st = '0; m_en = '0; m_prv = '0;
      return;
    end
    for (int i = 0; i < N; i++) begin
      ev = 1'b0;
      if (!dis[i]) begin
        if (trig[i]) ev = (pin[i] == inv[i]);
        else if (inv[i]) ev = !pin[i] && m_prv[i];
        else ev = pin[i] && !m_prv[i];
      end
      nst[i] = m_st[i];
      if (clr_v && clr_m[i]) nst[i] = 1'b0;
      if (ev) nst[i] = 1'b1;
      nprv[i] = dis[i] ? 1'b0 : pin[i];
      nen[i] = m_en[i];
      if (en_c[i]) nen[i] = 1'b0;
      if (en_s[i]) nen[i] = 1'b1;
    end
    m_st = nst; m_en = nen; m_prv = nprv;
  endtask

  task automatic compare();
    bit exp_irq;
    exp_irq = |(m_st & m_en);
    checks++;
    if (status !== m_st) begin
      fails++;
      $display("FAIL %s status actual=%h expected=%h", tag, status, m_st);
    end
    checks++;
    if (enable !== m_en) begin
      fails++;
      $display("FAIL %s/R10 enable actual=%h expected=%h", tag, enable, m_en);
    end
    checks++;
    if (irq !== exp_irq) begin
      fails++;
      $display("FAIL %s/R11 irq actual=%b expected=%b", tag, irq, exp_irq);
    end
  endtask

  // one clock: model at posedge, compare at negedge, then drop strobes
  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      model_update();
      @(negedge clk);
      compare();
      clr_v = 1'b0; clr_m = '0; en_s = '0; en_c = '0;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state
    tag = "R1";
    step(3);
    rst_n = 1'b1;
    step(2);

    // R10: enable set/clear, set wins
    tag = "R10";
    en_s = 32'h0000_00FF; step();
    en_s = 32'h0000_0008; en_c = 32'h0000_0028; step();
    en_c = 32'h0000_0001; step();
    en_s = 32'h0000_0001; step();

    // R2: rising edge on pin 0
    tag = "R2";
    pin[0] = 1'b1; step();
    step(2);
    pin[0] = 1'b0; step(2);

    // R3: falling edge on pin 1
    tag = "R3";
    inv[1] = 1'b1;
    pin[1] = 1'b1; step(2);
    pin[1] = 1'b0; step(2);

    // R6: selective clear, then clear all
    tag = "R6";
    clr_v = 1'b1; clr_m = 32'h0000_0001; step();
    clr_v = 1'b1; clr_m = '1; step(2);

    // R4: low level re-arms after clear
    tag = "R4";
    trig[2] = 1'b1; step(2);
    clr_v = 1'b1; clr_m = 32'h0000_0004; step(2);
    pin[2] = 1'b1; step();
    clr_v = 1'b1; clr_m = 32'h0000_0004; step(2);
    trig[2] = 1'b0; pin[2] = 1'b0; step();

    // R5: high level
    tag = "R5";
    trig[3] = 1'b1; inv[3] = 1'b1; step(2);
    pin[3] = 1'b1; step();
    clr_v = 1'b1; clr_m = 32'h0000_0008; step();
    pin[3] = 1'b0; step();
    clr_v = 1'b1; clr_m = 32'h0000_0008; step(2);
    trig[3] = 1'b0; inv[3] = 1'b0; step();

    // R7: edge coincident with clear
    tag = "R7";
    clr_v = 1'b1; clr_m = '1; step();
    pin[0] = 1'b1; clr_v = 1'b1; clr_m = 32'h0000_0001; step(2);
    pin[0] = 1'b0; step();

    // R8: sensing off blocks events, re-enable with pin high
    tag = "R8";
    dis[4] = 1'b1; pin[4] = 1'b1; step();
    pin[4] = 1'b0; step();
    pin[4] = 1'b1; step(2);
    dis[4] = 1'b0; step(2);
    pin[4] = 1'b0; step();

    // R9: latch while masked, then enable raises irq
    tag = "R9";
    clr_v = 1'b1; clr_m = '1; en_c = '1; step();
    pin[20] = 1'b1; step(3);
    tag = "R11";
    en_s = 32'h0010_0000; step(2);
    clr_v = 1'b1; clr_m = 32'h0010_0000; step(2);

    // mixed traffic across all modes
    tag = "R11";
    for (int c = 0; c < 400; c++) begin
      pin   = $urandom;
      trig  = $urandom & $urandom;
      inv   = $urandom;
      dis   = $urandom & $urandom & $urandom;
      clr_v = ($urandom % 3) == 0;
      clr_m = $urandom;
      en_s  = $urandom & $urandom;
      en_c  = $urandom & $urandom;
      step();
    end

    finish_run();
  end
endmodule